// File: doc/BRIEF.md
# SCL Clock Generator

This block derives the serial clock of a two-wire bus master from the system clock. The timing has two stages. A 7-bit divisor first turns the system clock into a reference tick of about 10 MHz. Two 8-bit counts then set the length of the low phase and the high phase of SCL, each measured in reference ticks. Software normally programs the divisor as (system clock in MHz + 5) / 10, rounded down. It programs each half-period count as ((10000 / f) + 1) / 2 for a target rate of f kHz. The count must stay non-zero; the slowest intended rate, 20 kHz, gives a count of 250.

The block pulls SCL low for the programmed low phase and then lets it go. It starts counting the high phase only once the line is actually sensed high. A target device that holds SCL low to stretch the clock therefore lengthens the released phase by exactly the time it holds the line. The reference tick is also given to the bit engine as a clock enable. A fast-mode flag, which software sets for rates above 100 kHz, is passed straight through to the bit engine.

Registers are written through a one-cycle write port. A select input chooses between the control word and the divider word.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, `scl_pull` and `ref_tick` are 0, `fast_mode` is 0, and generation is disabled.
- R2: A write with `wr_sel`=0 loads the control word. Bits [6:0] are the prescale P, bit 7 is the enable and bit 8 is the fast flag. `fast_mode` equals bit 8 from the cycle after the write.
- R3: While generation runs, consecutive `ref_tick` pulses inside one SCL phase are exactly P system cycles apart.
- R4: A write with `wr_sel`=1 loads the divider word. Bits [15:8] are the high count H and bits [7:0] are the low count L.
- R5: Every low phase holds `scl_pull`=1 for exactly L×P system cycles, including the first low phase after the enable is set.
- R6: A prescale or phase count of zero behaves as one.
- R7: Each released phase lasts 1 + S + H×P system cycles, where S is the number of cycles in which SCL is sensed low after release. Counting of the high phase starts only from the first cycle in which `scl_in` is high.
- R8: When the enable is cleared, `scl_pull` and `ref_tick` are 0 from the second cycle after the write on, and they stay 0 while the enable is clear.
- R9: Data presented while `wr_en`=0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | 0 = control word, 1 = divider word |
| wr_data | input | 16 | Register write data |
| scl_in | input | 1 | Sensed level of the SCL line |
| ref_tick | output | 1 | Reference tick, a one-cycle clock enable for the bit engine |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release SCL |
| fast_mode | output | 1 | Fast-mode flag from the control word |

## Verification
The assertions check the following on every cycle:
- the prescaler wraps after each tick;
- a low phase is left only on a tick;
- the high phase starts only after SCL has been sensed high, and a stretched wait cannot move into the high phase;
- when the enable is cleared, the output goes quiet within the stated delay;
- register contents hold without a write strobe.

Only the bench scenarios can show the exact phase lengths in system cycles for several prescale and count settings. The bench compares each measured SCL segment against its own formula. These scenarios also show the extra released time under a stretching target, and the zero-counts-as-one rule at the fastest setting.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Index of the last tick in a phase; a zero count acts as one (R6).
  function automatic int unsigned last_index(int unsigned raw);
    return (raw == 0) ? 0 : raw - 1;
  endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int PRESC_W = 7,
  parameter int CNT_W   = 8,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [PRESC_W-1:0] presc,
  output logic               gen_en,
  output logic               fast,
  output logic [CNT_W-1:0]   hi_cnt,
  output logic [CNT_W-1:0]   lo_cnt
);
  localparam int EN_BIT   = PRESC_W;
  localparam int FAST_BIT = PRESC_W + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      gen_en <= 1'b0;
      fast   <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (wr_en) begin
      if (!wr_sel) begin
        presc  <= wr_data[PRESC_W-1:0];
        gen_en <= wr_data[EN_BIT];
        fast   <= wr_data[FAST_BIT];
      end else begin
        hi_cnt <= wr_data[DATA_W-1:CNT_W];
        lo_cnt <= wr_data[CNT_W-1:0];
      end
    end
  end

  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({presc, gen_en, fast, hi_cnt, lo_cnt}));

  assert_fast_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (fast == $past(wr_data[FAST_BIT])));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRESC_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  import scl_clkgen_pkg::*;

  logic [PRESC_W-1:0] pcnt;
  logic [PRESC_W-1:0] p_last;

  assign p_last = PRESC_W'(last_index(32'(presc)));
  assign tick   = run && (pcnt >= p_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pcnt <= '0;
    else if (!run || restart || tick) pcnt <= '0;
    else                             pcnt <= pcnt + PRESC_W'(1);
  end

  assert_tick_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             tick,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             running,
  output logic             restart,
  output logic             scl_pull
);
  import scl_clkgen_pkg::*;

  scl_phase_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lo_last, hi_last;
  logic             low_done, high_done;

  assign lo_last   = CNT_W'(last_index(32'(lo_cnt)));
  assign hi_last   = CNT_W'(last_index(32'(hi_cnt)));
  assign low_done  = (st == PH_LOW)  && tick && (cnt >= lo_last);
  assign high_done = (st == PH_HIGH) && tick && (cnt >= hi_last);
  assign restart   = (st == PH_WAIT) && scl_in;
  assign running   = (st != PH_OFF);
  assign scl_pull  = (st == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PH_OFF;
      cnt <= '0;
    end else if (!gen_en) begin
      st  <= PH_OFF;
      cnt <= '0;
    end else begin
      case (st)
        PH_OFF: begin
          st  <= PH_LOW;
          cnt <= '0;
        end
        PH_LOW: begin
          if (low_done) begin
            st  <= PH_WAIT;
            cnt <= '0;
          end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_WAIT: begin
          if (restart) begin
            st  <= PH_HIGH;
            cnt <= '0;
          end
        end
        default: begin
          if (high_done) begin
            st  <= PH_LOW;
            cnt <= '0;
          end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assert_low_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_LOW && !tick) |=> (st == PH_LOW || st == PH_OFF));

  assert_wait_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_WAIT && !scl_in) |=> (st == PH_WAIT || st == PH_OFF));

  assert_high_after_sense_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == PH_HIGH) |-> $past(scl_in));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int PRESC_W = 7,
  parameter int CNT_W   = 8,
  localparam int DATA_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              scl_in,
  output logic              ref_tick,
  output logic              scl_pull,
  output logic              fast_mode
);
  logic [PRESC_W-1:0] presc;
  logic               gen_en;
  logic [CNT_W-1:0]   hi_cnt, lo_cnt;
  logic               running, restart;

  scl_cfg_regs #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .presc(presc), .gen_en(gen_en), .fast(fast_mode),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt)
  );

  scl_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(restart),
    .presc(presc), .tick(ref_tick)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .tick(ref_tick),
    .scl_in(scl_in), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .running(running), .restart(restart), .scl_pull(scl_pull)
  );

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!ref_tick && !scl_pull));

endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, wr_sel, hold;
  logic [15:0] wr_data;
  logic        scl_in, ref_tick, scl_pull, fast_mode;

  always #10 clk = ~clk;

  assign scl_in = ~scl_pull & ~hold;

  scl_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .scl_in(scl_in), .ref_tick(ref_tick),
    .scl_pull(scl_pull), .fast_mode(fast_mode)
  );

  int    n_chk = 0, n_bad = 0;
  bit    q_lvl[$];
  int    q_len[$];
  string q_tag[$];

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(bit lvl, int len, string tag);
    q_lvl.push_back(lvl);
    q_len.push_back(len);
    q_tag.push_back(tag);
  endtask

  // Monitor: measures each SCL segment and compares it with the queue head.
  bit prev = 1'b0;
  int run_len = 0;
  always @(negedge clk) begin
    if (rst_n && scl_pull != prev) begin
      if (q_len.size() > 0) begin
        bit    el;
        int    en;
        string et;
        el = q_lvl.pop_front();
        en = q_len.pop_front();
        et = q_tag.pop_front();
        check(el == prev && en == run_len, et, run_len, en);
      end
      prev    = scl_pull;
      run_len = 1;
    end else begin
      run_len++;
    end
  end

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int one_min(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Driver: programs a pattern and queues the expected segment lengths.
  task automatic run_pattern(int p, int h, int l, int s, string tl, string th);
    int pe, he, le;
    pe = one_min(p); he = one_min(h); le = one_min(l);
    wr(1'b1, {h[7:0], l[7:0]});                   // R4 divider fields
    hold = (s > 0);
    wr(1'b0, 16'h0080 | 16'(p));                  // R2 enable, prescale
    while (!scl_pull) @(negedge clk);
    @(posedge clk);
    push(1'b1, le * pe, tl);
    push(1'b0, 1 + s + he * pe, th);
    push(1'b1, le * pe, tl);
    push(1'b0, 1 + he * pe, th);
    push(1'b1, le * pe, tl);
    if (s > 0) begin
      @(negedge clk);
      while (scl_pull) @(negedge clk);
      repeat (s) @(negedge clk);
      hold = 1'b0;
    end
    while (q_len.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_pull == 1'b0, "R1 pull after reset", int'(scl_pull), 0);
    check(ref_tick == 1'b0, "R1 tick after reset", int'(ref_tick), 0);
    check(fast_mode == 1'b0, "R1 fast after reset", int'(fast_mode), 0);

    // R2: fast flag from control bit 8
    wr(1'b0, 16'h0100);
    check(fast_mode == 1'b1, "R2 fast flag set", int'(fast_mode), 1);
    // R9: data without strobe is ignored
    wr_sel = 1'b0; wr_data = 16'h0000;
    repeat (3) @(negedge clk);
    check(fast_mode == 1'b1, "R9 no-strobe write ignored", int'(fast_mode), 1);
    check(scl_pull == 1'b0, "R9 no enable without strobe", int'(scl_pull), 0);
    wr(1'b0, 16'h0000);
    check(fast_mode == 1'b0, "R2 fast flag cleared", int'(fast_mode), 0);

    // Pattern A: P=5, H=4, L=3
    run_pattern(5, 4, 3, 0, "R5 low phase A", "R7 released phase A");
    begin
      logic was;
      int cyc, nt, first, gap;
      do begin was = scl_pull; @(negedge clk); end while (!(scl_pull && !was));
      cyc = 0; nt = 0; first = -1; gap = -1;
      while (scl_pull) begin
        if (ref_tick) begin
          nt++;
          if (first < 0) first = cyc;
          else if (gap < 0) gap = cyc - first;
        end
        cyc++;
        @(negedge clk);
      end
      check(nt == 3, "R3 ticks per low phase", nt, 3);
      check(gap == 5, "R3 tick spacing", gap, 5);
    end

    // R8: disable releases SCL and silences the tick
    wr(1'b0, 16'h0000);
    @(negedge clk);
    begin
      int busy;
      busy = 0;
      for (int i = 0; i < 20; i++) begin
        if (scl_pull || ref_tick) busy++;
        @(negedge clk);
      end
      check(busy == 0, "R8 quiet while disabled", busy, 0);
    end
    check(scl_pull == 1'b0, "R8 SCL released", int'(scl_pull), 0);

    // Pattern B: clock stretching, P=3, H=2, L=2, held 7 cycles
    run_pattern(3, 2, 2, 7, "R5 low phase B", "R7 stretched released phase B");
    wr(1'b0, 16'h0000);
    repeat (4) @(negedge clk);

    // Pattern C: all zero counts act as one
    run_pattern(0, 0, 0, 0, "R6 zero-count low phase", "R6 zero-count released phase");
    wr(1'b0, 16'h0000);
    repeat (4) @(negedge clk);

    // Pattern D: asymmetric counts, P=2, H=1, L=6
    run_pattern(2, 1, 6, 0, "R5 low phase D", "R7 released phase D");
    wr(1'b0, 16'h0000);
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule